// File: doc/BRIEF.md
# Attribute-Masked Register Bank

A bank of 32-bit control and status registers sitting behind a simple single-cycle memory-mapped port. Every bit of every register has attributes fixed at build time through parameters. These are the value after reset, read-only, write-one-to-clear, reserved, clear-on-read and unimplemented. A bus write does not simply overwrite a register. The written word is merged with the stored word, so only bits that are writable and lie within the bytes covered by the access change. Bits marked write-one-to-clear are then knocked down wherever the data carries a one.

A read returns the stored word, trimmed to the access size, one clock after the strobe. It also clears any clear-on-read bits inside the bytes that were read. Hardware logic beside the bank can raise individual bits through a set vector, and a set always wins over a clear in the same cycle. Three one-cycle flags report an access to an unmapped address, a write that tries to alter reserved bits, and a write that puts a one on an unimplemented bit.

Top module: `attr_regbank`

## Requirements
- R1: Reset loads every register with its own reset value and drives read data and all three flags to zero.
- R2: A write to a mapped register copies the data onto the bits that lie in the written bytes and are not read-only, write-one-to-clear or reserved. All other bits keep their old value, so read-only bits never change through the bus.
- R3: Access size encoding on `bus_size` is 0 for one byte (bits 7:0), 1 for two bytes (bits 15:0), and 2 or 3 for four bytes. A write leaves bits outside those bytes untouched, and read data is zero above them.
- R4: After the merge, a write clears every write-one-to-clear bit where the 32-bit write data has a one, whatever the access size. Bits written with zero are kept.
- R5: Read data is registered. It shows the pre-clear register contents, masked to the access size, in the cycle after `bus_rd`, and it holds until the next read strobe.
- R6: A read clears in storage those clear-on-read bits that lie inside the bytes read, and only those.
- R7: An address that is not a multiple of 4, or whose word index (address divided by 4) is not below the register count, is unmapped. A write there changes nothing, a read there returns zero, and `err_miss` pulses high for one cycle after the strobe.
- R8: A mapped write whose full data word differs from the old value on any reserved bit pulses `err_rsvd` one cycle later. The masked write still completes.
- R9: A mapped write with a one on any unimplemented bit pulses `err_unimp` one cycle later. Unimplemented bits are otherwise stored like ordinary writable bits.
- R10: A one on `hw_set` (bit 32*i+b for register i, bit b) sets that bit in the next cycle unless it is reserved. This takes priority over a bus write, a write-one-to-clear or a clear-on-read in the same cycle.
- R11: When `bus_wr` and `bus_rd` are both high, only the write is performed. No clear-on-read takes place, and read data loads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| bus_rdata | output | 32 | Registered read data |
| hw_set | input | NUM_REGS*32 | Per-bit set requests from hardware |
| err_miss | output | 1 | Unmapped access pulse |
| err_rsvd | output | 1 | Reserved-bit change pulse |
| err_unimp | output | 1 | Unimplemented-bit write pulse |

## Verification
The per-register properties rely on the top never presenting a read and a write to the same register in one cycle. They also rely on the attribute parameters keeping reserved bits out of `hw_set` effects, which the cell guarantees. The port-level properties assume each strobe describes one access per clock. The stimulus changes the bus and `hw_set` only at falling edges and holds each strobe for exactly one rising edge. It keeps `hw_set` at zero during the vector walk, so the merge, clear and flag results there depend on the bus alone.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // Byte lanes enabled by an access of the given size on a 32-bit register.
  function automatic word_t lane_mask(input logic [1:0] sz);
    word_t m;
    case (acc_size_e'(sz))
      SZ_BYTE: m = 32'h0000_00FF;
      SZ_HALF: m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int AW       = 8,
  parameter int NUM_REGS = 4,
  localparam int IW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);

  logic [AW-3:0] word_idx;

  assign word_idx = addr[AW-1:2];

  always_comb begin
    hit = (addr[1:0] == 2'b00) && (32'(word_idx) < NUM_REGS);
    idx = word_idx[IW-1:0];
  end

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter word_t RST_VAL   = '0,
  parameter word_t RO_MASK   = '0,
  parameter word_t W1C_MASK  = '0,
  parameter word_t RSVD_MASK = '0,
  parameter word_t COR_MASK  = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  word_t wdata,
  input  word_t lane_en,
  input  word_t hw_set,
  output word_t q
);

  word_t q_r;
  word_t q_d;
  word_t keep_m;
  logic  upd;

  // Next-state: bus merge or read clear, then hardware set on top.
  always_comb begin
    keep_m = RO_MASK | W1C_MASK | RSVD_MASK | ~lane_en;
    q_d    = q_r;
    if (wr_en) begin
      q_d = (wdata & ~keep_m) | (q_r & keep_m);
      q_d = q_d & ~(wdata & W1C_MASK);
    end else if (rd_en) begin
      q_d = q_r & ~(COR_MASK & lane_en);
    end
    q_d = q_d | (hw_set & ~RSVD_MASK);
    upd = wr_en | rd_en | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (upd) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  AST_RO_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> ((q & ~$past(q) & RO_MASK & ~$past(hw_set)) == '0)); // R2

  AST_LANES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(lane_en) & ~W1C_MASK & ~$past(hw_set)) == '0)); // R3

  AST_W1C_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(wdata) & W1C_MASK & ~$past(hw_set)) == '0)); // R4

  AST_COR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((q & COR_MASK & $past(lane_en) & ~$past(hw_set)) == '0)); // R6

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set) & ~RSVD_MASK) == ($past(hw_set) & ~RSVD_MASK))); // R10

endmodule

// File: rtl/attr_regbank.sv
module attr_regbank
  import regbank_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*WORD_W-1:0] RST_VALS    =
    {32'hC0DE_0003, 32'h1234_5678, 32'h0000_00F0, 32'h0000_00A5},
  parameter logic [NUM_REGS*WORD_W-1:0] RO_MASKS    =
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFF00_0000},
  parameter logic [NUM_REGS*WORD_W-1:0] W1C_MASKS   =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000},
  parameter logic [NUM_REGS*WORD_W-1:0] RSVD_MASKS  =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_F000},
  parameter logic [NUM_REGS*WORD_W-1:0] COR_MASKS   =
    {32'h0000_0000, 32'hF0F0_F0F0, 32'h0000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS*WORD_W-1:0] UNIMP_MASKS =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h00F0_0000},
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [WORD_W-1:0]          bus_wdata,
  input  logic [1:0]                 bus_size,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic [NUM_REGS*WORD_W-1:0] hw_set,
  output logic                       err_miss,
  output logic                       err_rsvd,
  output logic                       err_unimp
);

  logic          hit;
  logic [IW-1:0] idx;
  word_t         lane;
  logic          wr_go;
  logic          rd_go;

  word_t               q_arr [NUM_REGS];
  logic [NUM_REGS-1:0] sel_v;
  logic [NUM_REGS-1:0] rsvd_v;
  logic [NUM_REGS-1:0] unimp_v;

  word_t rd_word;
  word_t rdata_d, rdata_q;
  logic  rdata_en;
  logic  miss_d, miss_q;
  logic  rsvd_d, rsvd_q;
  logic  unimp_d, unimp_q;

  regbank_decode #(
    .AW       (AW),
    .NUM_REGS (NUM_REGS)
  ) dec_i (
    .addr (bus_addr),
    .hit  (hit),
    .idx  (idx)
  );

  always_comb begin
    lane  = lane_mask(bus_size);
    wr_go = bus_wr & hit;
    rd_go = bus_rd & ~bus_wr & hit;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam word_t RSVD_I  = RSVD_MASKS[i*WORD_W +: WORD_W];
    localparam word_t UNIMP_I = UNIMP_MASKS[i*WORD_W +: WORD_W];

    assign sel_v[i]   = hit && (idx == IW'(i));
    assign rsvd_v[i]  = sel_v[i] && (((q_arr[i] ^ bus_wdata) & RSVD_I) != '0);
    assign unimp_v[i] = sel_v[i] && ((bus_wdata & UNIMP_I) != '0);

    regbank_cell #(
      .RST_VAL   (RST_VALS[i*WORD_W +: WORD_W]),
      .RO_MASK   (RO_MASKS[i*WORD_W +: WORD_W]),
      .W1C_MASK  (W1C_MASKS[i*WORD_W +: WORD_W]),
      .RSVD_MASK (RSVD_I),
      .COR_MASK  (COR_MASKS[i*WORD_W +: WORD_W])
    ) cell_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_go & sel_v[i]),
      .rd_en   (rd_go & sel_v[i]),
      .wdata   (bus_wdata),
      .lane_en (lane),
      .hw_set  (hw_set[i*WORD_W +: WORD_W]),
      .q       (q_arr[i])
    );
  end

  // Read select and flag next-state.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_v[i]) rd_word = q_arr[i];
    end
    rdata_en = bus_rd;
    rdata_d  = rd_go ? (rd_word & lane) : '0;
    miss_d   = (bus_rd | bus_wr) & ~hit;
    rsvd_d   = bus_wr & (|rsvd_v);
    unimp_d  = bus_wr & (|unimp_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q  <= 1'b0;
      rsvd_q  <= 1'b0;
      unimp_q <= 1'b0;
    end else begin
      miss_q  <= miss_d;
      rsvd_q  <= rsvd_d;
      unimp_q <= unimp_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign err_miss  = miss_q;
  assign err_rsvd  = rsvd_q;
  assign err_unimp = unimp_q;

  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_size == 2'd0) |=> (bus_rdata[31:8] == '0)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R5

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> (err_miss && bus_rdata == '0)); // R7

  AST_FLAG_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (!err_rsvd && !err_unimp)); // R8

  AST_COLLIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> (bus_rdata == '0)); // R11

endmodule

// File: tb/attr_regbank_tb_top.sv
module attr_regbank_tb_top;

  localparam int NR = 4;
  localparam int HW = NR * 32;

  logic          clk;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_wr;
  logic          bus_rd;
  logic [31:0]   bus_wdata;
  logic [1:0]    bus_size;
  logic [31:0]   bus_rdata;
  logic [HW-1:0] hw_set;
  logic          err_miss;
  logic          err_rsvd;
  logic          err_unimp;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  attr_regbank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .hw_set    (hw_set),
    .err_miss  (err_miss),
    .err_rsvd  (err_rsvd),
    .err_unimp (err_unimp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [7:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [2:0]  exp_flags; // {miss, rsvd, unimp}
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h00, 2'd2, 32'h0,         32'h0000_00A5, 3'b000}, // R1
    '{1'b0, 1'b1, 8'h04, 2'd2, 32'h0,         32'h0000_00F0, 3'b000}, // R1
    '{1'b0, 1'b1, 8'h0C, 2'd2, 32'h0,         32'hC0DE_0003, 3'b000}, // R1
    '{1'b1, 1'b0, 8'h00, 2'd2, 32'h00FF_0FFF, 32'h0,         3'b001}, // R9
    '{1'b0, 1'b1, 8'h00, 2'd2, 32'h0,         32'h00FF_0FFF, 3'b000}, // R2 R9
    '{1'b1, 1'b0, 8'h00, 2'd2, 32'h0000_F123, 32'h0,         3'b010}, // R8
    '{1'b0, 1'b1, 8'h00, 2'd2, 32'h0,         32'h0000_0123, 3'b000}, // R8
    '{1'b1, 1'b0, 8'h00, 2'd0, 32'hAA0A_0A5C, 32'h0,         3'b000}, // R3
    '{1'b0, 1'b1, 8'h00, 2'd1, 32'h0,         32'h0000_015C, 3'b000}, // R3
    '{1'b0, 1'b1, 8'h00, 2'd0, 32'h0,         32'h0000_005C, 3'b000}, // R3
    '{1'b1, 1'b0, 8'h04, 2'd2, 32'h0000_0030, 32'h0,         3'b000}, // R4
    '{1'b0, 1'b1, 8'h04, 2'd2, 32'h0,         32'h0000_00C0, 3'b000}, // R4
    '{1'b1, 1'b0, 8'h04, 2'd0, 32'h1234_0080, 32'h0,         3'b000}, // R4
    '{1'b0, 1'b1, 8'h04, 2'd3, 32'h0,         32'h0000_0040, 3'b000}, // R4
    '{1'b0, 1'b1, 8'h08, 2'd1, 32'h0,         32'h0000_5678, 3'b000}, // R6
    '{1'b0, 1'b1, 8'h08, 2'd2, 32'h0,         32'h1234_0608, 3'b000}, // R6
    '{1'b0, 1'b1, 8'h08, 2'd2, 32'h0,         32'h0204_0608, 3'b000}, // R6
    '{1'b1, 1'b0, 8'h0C, 2'd2, 32'hFFFF_FFFF, 32'h0,         3'b000}, // R2
    '{1'b0, 1'b1, 8'h0C, 2'd2, 32'h0,         32'hC0DE_0003, 3'b000}, // R2
    '{1'b1, 1'b0, 8'h10, 2'd2, 32'hFFFF_FFFF, 32'h0,         3'b100}, // R7
    '{1'b0, 1'b1, 8'h10, 2'd2, 32'h0,         32'h0,         3'b100}, // R7
    '{1'b0, 1'b1, 8'h02, 2'd2, 32'h0,         32'h0,         3'b100}, // R7
    '{1'b1, 1'b0, 8'h05, 2'd2, 32'h0,         32'h0,         3'b100}, // R7
    '{1'b0, 1'b1, 8'h04, 2'd2, 32'h0,         32'h0000_0040, 3'b000}, // R7
    '{1'b1, 1'b0, 8'h08, 2'd1, 32'hFFFF_BEEF, 32'h0,         3'b000}, // R3
    '{1'b0, 1'b1, 8'h08, 2'd2, 32'h0,         32'h0204_BEEF, 3'b000}, // R3 R6
    '{1'b0, 1'b1, 8'h08, 2'd2, 32'h0,         32'h0204_0E0F, 3'b000}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Starts at a falling edge, spans one rising edge, ends at the next falling edge.
  task automatic op(input logic w, input logic r, input logic [7:0] a, input logic [1:0] s,
                    input logic [31:0] d, input logic [HW-1:0] hs);
    bus_wr    = w;
    bus_rd    = r;
    bus_addr  = a;
    bus_size  = s;
    bus_wdata = d;
    hw_set    = hs;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    hw_set = '0;
  endtask

  function automatic logic [HW-1:0] hs_at(input int r, input logic [31:0] bits);
    logic [HW-1:0] v;
    v = '0;
    v[r*32 +: 32] = bits;
    return v;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0;
    bus_size = 2'd2; bus_wdata = '0; hw_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset flags", {29'd0, err_miss, err_rsvd, err_unimp}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      op(VEC[k].wr, VEC[k].rd, VEC[k].addr, VEC[k].sz, VEC[k].wdata, '0);
      chk($sformatf("vec %0d flags", k), {29'd0, err_miss, err_rsvd, err_unimp},
          {29'd0, VEC[k].exp_flags});
      if (VEC[k].rd) chk($sformatf("vec %0d rdata", k), bus_rdata, VEC[k].exp_rd);
    end

    // R10: set beats write-one-to-clear in the same cycle
    op(1, 0, 8'h04, 2'd2, 32'h0000_0001, hs_at(1, 32'h0000_0003));
    op(0, 1, 8'h04, 2'd2, 32'h0, '0);
    chk("R10 set over W1C", bus_rdata, 32'h0000_0043);

    // R10: set beats clear-on-read; read returns pre-set contents
    op(0, 1, 8'h08, 2'd2, 32'h0, hs_at(2, 32'h0000_0010));
    chk("R10 read during set", bus_rdata, 32'h0204_0E0F);
    op(0, 1, 8'h08, 2'd2, 32'h0, '0);
    chk("R10 set over COR", bus_rdata, 32'h0204_0E1F);
    op(0, 1, 8'h08, 2'd2, 32'h0, '0);
    chk("R6 COR after set", bus_rdata, 32'h0204_0E0F);

    // R10: set on a reserved bit has no effect
    op(0, 0, 8'h00, 2'd2, 32'h0, hs_at(0, 32'h0000_8000));
    op(0, 1, 8'h00, 2'd2, 32'h0, '0);
    chk("R10 reserved set ignored", bus_rdata, 32'h0000_015C);

    // R5: read data holds with no strobe
    op(0, 0, 8'h04, 2'd2, 32'hFFFF_FFFF, '0);
    chk("R5 rdata hold", bus_rdata, 32'h0000_015C);

    // R7: miss flag is a single-cycle pulse
    op(0, 1, 8'h1C, 2'd2, 32'h0, '0);
    chk("R7 miss raised", {31'd0, err_miss}, 32'h1);
    op(0, 0, 8'h00, 2'd2, 32'h0, '0);
    chk("R7 miss pulse ends", {31'd0, err_miss}, 32'h0);

    // R11: read and write together
    op(1, 1, 8'h08, 2'd2, 32'h1111_1111, '0);
    chk("R11 collide rdata", bus_rdata, 32'h0);
    op(0, 1, 8'h08, 2'd2, 32'h0, '0);
    chk("R11 write done, no COR", bus_rdata, 32'h1111_1111);
    op(0, 1, 8'h08, 2'd2, 32'h0, '0);
    chk("R11 COR on later read", bus_rdata, 32'h0101_0101);

    // R1: reset in mid-run restores everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 1, 8'h00, 2'd2, 32'h0, '0);
    chk("R1 reg0 after reset", bus_rdata, 32'h0000_00A5);
    op(0, 1, 8'h08, 2'd2, 32'h0, '0);
    chk("R1 reg2 after reset", bus_rdata, 32'h1234_5678);

    summary();
  end

endmodule